// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block decodes the fetched instruction of a 32-bit single-cycle processor into the control lines that steer its datapath. It reads only two fields: the 6-bit opcode in bits 31-26 and the 6-bit function code in bits 5-0. It is purely combinational, so its outputs follow its inputs within the same cycle.

Decoding happens in two levels. A main decoder looks at the opcode. It raises the register-write, operand-source, write-back-source, destination-select, memory and program-flow strobes. It also picks a 2-bit ALU class: add, subtract, look at the function code, or reserved. A second stage turns that class, together with the function code, into a 3-bit operation code for the primary ALU.

An opcode the decoder does not recognise disables every strobe that could change state. An unlisted function code falls back to addition.

Top module: `instrDecoder`

## Requirements
- R1: Opcode 000000 (register format) drives regWrite=1, regDst=1, and 0 on aluSrc, memToReg, memRead, memWrite, branch and jump.
- R2: Opcode 100011 (load word) drives regWrite=1, aluSrc=1, memToReg=1, memRead=1, and 0 on regDst, memWrite, branch and jump.
- R3: Opcode 101011 (store word) drives aluSrc=1, memWrite=1, and 0 on regWrite, memRead, branch, jump, memToReg and regDst.
- R4: Opcode 000100 (branch on equal) drives branch=1 and 0 on every other strobe.
- R5: Opcode 000010 (jump) drives jump=1 and 0 on every other strobe.
- R6: Any other opcode drives all eight strobes to 0, and aluOp to 100.
- R7: For load word, store word and jump, aluOp is 100 (add), whatever the function code.
- R8: For branch on equal, aluOp is 101 (subtract), whatever the function code.
- R9: For register format, the function code selects aluOp as follows: 100100 gives and=000; 100101 gives or=010; 100000 gives add=100; 100010 gives sub=101; 101010 gives set-less-than=111.
- R10: For register format with any other function code, aluOp is 100 (add).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31-26 |
| funct | input | 6 | Instruction bits 5-0 |
| regWrite | output | 1 | Write the register file |
| aluSrc | output | 1 | Second ALU operand is the immediate (1) or a register (0) |
| memToReg | output | 1 | Write-back data comes from memory (1) or the ALU (0) |
| regDst | output | 1 | Destination register is bits 15-11 (1) or bits 20-16 (0) |
| memRead | output | 1 | Read data memory |
| memWrite | output | 1 | Write data memory |
| branch | output | 1 | Conditional branch instruction; combined with the ALU zero flag outside the block |
| jump | output | 1 | Unconditional jump instruction |
| aluOp | output | 3 | Primary ALU operation code |

## Verification
The assertions are immediate checks. They are evaluated only while both input fields are free of X and Z, because an unknown opcode gives no meaningful decode. The bench never drives an unknown value after its first step. It sweeps every opcode against every function code, so each of the 4096 input pairs is a known, settled pattern when the outputs are compared.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 3;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_RSVD = 2'b11
  } aluClass_e;

  typedef struct packed {
    logic      regWrite;
    logic      aluSrc;
    logic      memToReg;
    logic      regDst;
    logic      memRead;
    logic      memWrite;
    logic      branch;
    logic      jump;
    aluClass_e aluClass;
  } ctrlStrobes_t;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [ALU_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_W-1:0] ALU_OR  = 3'b010;
  localparam logic [ALU_W-1:0] ALU_ADD = 3'b100;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b101;
  localparam logic [ALU_W-1:0] ALU_SLT = 3'b111;
endpackage

// File: rtl/idec_main.sv
module idec_main
  import idec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrlStrobes_t    strobes
);
  always_comb begin
    strobes = '{default: '0, aluClass: CLS_ADD};
    unique case (opcode)
      OPC_RTYPE: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
        strobes.aluClass = CLS_FUNC;
      end
      OPC_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.aluSrc   = 1'b1;
        strobes.memToReg = 1'b1;
        strobes.memRead  = 1'b1;
      end
      OPC_STORE: begin
        strobes.aluSrc   = 1'b1;
        strobes.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        strobes.branch   = 1'b1;
        strobes.aluClass = CLS_SUB;
      end
      OPC_JUMP: begin
        strobes.jump     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_alu.sv
module idec_alu
  import idec_pkg::*;
(
  input  aluClass_e        aluClass,
  input  logic [FN_W-1:0]  funct,
  output logic [ALU_W-1:0] aluOp
);
  logic [ALU_W-1:0] functOp;

  always_comb begin
    case (funct)
      FN_ADD:  functOp = ALU_ADD;
      FN_SUB:  functOp = ALU_SUB;
      FN_AND:  functOp = ALU_AND;
      FN_OR:   functOp = ALU_OR;
      FN_SLT:  functOp = ALU_SLT;
      default: functOp = ALU_ADD;
    endcase
  end

  always_comb begin
    case (aluClass)
      CLS_SUB:  aluOp = ALU_SUB;
      CLS_FUNC: aluOp = functOp;
      default:  aluOp = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import idec_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       regWrite,
  output logic       aluSrc,
  output logic       memToReg,
  output logic       regDst,
  output logic       memRead,
  output logic       memWrite,
  output logic       branch,
  output logic       jump,
  output logic [2:0] aluOp
);
  ctrlStrobes_t strobes;

  idec_main u_main (
    .opcode  (opcode),
    .strobes (strobes)
  );

  idec_alu u_alu (
    .aluClass (strobes.aluClass),
    .funct    (funct),
    .aluOp    (aluOp)
  );

  assign regWrite = strobes.regWrite;
  assign aluSrc   = strobes.aluSrc;
  assign memToReg = strobes.memToReg;
  assign regDst   = strobes.regDst;
  assign memRead  = strobes.memRead;
  assign memWrite = strobes.memWrite;
  assign branch   = strobes.branch;
  assign jump     = strobes.jump;
endmodule

// File: rtl/instrDecoder_chk.sv
module instrDecoder_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       regWrite,
  input logic       aluSrc,
  input logic       memToReg,
  input logic       regDst,
  input logic       memRead,
  input logic       memWrite,
  input logic       branch,
  input logic       jump,
  input logic [2:0] aluOp
);
  logic known;
  logic [7:0] strb;
  assign known = !$isunknown({opcode, funct});
  assign strb  = {regWrite, aluSrc, memToReg, regDst, memRead, memWrite, branch, jump};

  always_comb begin
    if (known) begin
      if (opcode == 6'b000000)
        p_rtype_strobes_r1: assert (strb == 8'b1001_0000);
      if (opcode == 6'b100011)
        p_load_strobes_r2: assert (strb == 8'b1110_1000);
      if (opcode == 6'b101011)
        p_store_strobes_r3: assert (strb == 8'b0100_0100);
      if (opcode == 6'b000100)
        p_beq_strobes_r4: assert (strb == 8'b0000_0010);
      if (opcode == 6'b000010)
        p_jump_strobes_r5: assert (strb == 8'b0000_0001);
      p_state_guard_r6: assert ($onehot0({regWrite, memWrite, branch, jump}));
      if (opcode == 6'b100011 || opcode == 6'b101011 || opcode == 6'b000010)
        p_addr_add_r7: assert (aluOp == 3'b100);
      if (opcode == 6'b000100)
        p_beq_sub_r8: assert (aluOp == 3'b101);
      if (opcode == 6'b000000 && funct == 6'b101010)
        p_slt_map_r9: assert (aluOp == 3'b111);
      if (opcode == 6'b000000 && funct[5] == 1'b0)
        p_funct_default_r10: assert (aluOp == 3'b100);
    end
  end
endmodule

bind instrDecoder instrDecoder_chk u_chk (.*);

// File: tb/instrDecoder_tb.sv
module instrDecoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [5:0] opcode, funct;
  logic regWrite, aluSrc, memToReg, regDst, memRead, memWrite, branch, jump;
  logic [2:0] aluOp;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  instrDecoder u_dut (
    .opcode(opcode), .funct(funct), .regWrite(regWrite), .aluSrc(aluSrc),
    .memToReg(memToReg), .regDst(regDst), .memRead(memRead),
    .memWrite(memWrite), .branch(branch), .jump(jump), .aluOp(aluOp)
  );

  // expected {strobes[7:0], aluOp[2:0]} from the requirement text
  function automatic logic [10:0] model(int op, int fn);
    logic [7:0] s;
    logic [2:0] a;
    a = 3'd4;
    if (op == 0) begin
      s = 8'b1001_0000;
      if (fn == 32) a = 3'd4;
      else if (fn == 34) a = 3'd5;
      else if (fn == 36) a = 3'd0;
      else if (fn == 37) a = 3'd2;
      else if (fn == 42) a = 3'd7;
    end else if (op == 35) s = 8'b1110_1000;
    else if (op == 43) s = 8'b0100_0100;
    else if (op == 4) begin s = 8'b0000_0010; a = 3'd5; end
    else if (op == 2) s = 8'b0000_0001;
    else s = 8'b0;
    return {s, a};
  endfunction

  function automatic string reqTag(int op, int fn);
    if (op == 0) return (fn == 32 || fn == 34 || fn == 36 || fn == 37 || fn == 42) ? "R1/R9" : "R1/R10";
    if (op == 35) return "R2/R7";
    if (op == 43) return "R3/R7";
    if (op == 4)  return "R4/R8";
    if (op == 2)  return "R5/R7";
    return "R6";
  endfunction

  task automatic compare(string req);
    logic [10:0] act, exp;
    act = {regWrite, aluSrc, memToReg, regDst, memRead, memWrite, branch, jump, aluOp};
    exp = model(int'(opcode), int'(funct));
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, opcode, funct, act, exp);
    end
  endtask

  task automatic apply(int op, int fn, string req);
    @(posedge clk);
    opcode <= 6'(op);
    funct  <= 6'(fn);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    opcode = 6'b111111;
    funct  = 6'b000000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R6 reset idle");
    rst = 1'b0;
    // directed corners
    apply(0, 36, "R9 and");
    apply(0, 37, "R9 or");
    apply(0, 32, "R9 add");
    apply(0, 34, "R9 sub");
    apply(0, 42, "R9 slt");
    apply(0, 63, "R10 default");
    apply(35, 34, "R2 R7 funct ignored");
    apply(43, 42, "R3 R7 funct ignored");
    apply(4, 36, "R4 R8 funct ignored");
    apply(2, 37, "R5 R7 funct ignored");
    apply(63, 34, "R6 unknown opcode");
    // exhaustive sweep, compared every clock
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        apply(op, fn, reqTag(op, fn));
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nTests++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule